// File: doc/BRIEF.md
# Burst SRAM cycle controller

This block is the synchronous control front end of a flow-through burst SRAM. Two address strobes compete for the start of a cycle. The processor-side strobe is gated by the master chip enable. The controller-side strobe is honoured whenever the processor strobe is not. An accepted strobe captures the address and opens a burst of up to four beats. The beat address is formed from the two low address bits and a 2-bit beat count, in either XOR (interleaved) or modulo-4 add (linear) order. An advance input moves the burst on by one beat; while it is high the burst is suspended.

Write enables are decoded from a global write input and from per-lane byte writes qualified by a byte-write enable. The decoded lanes drive the per-lane write strobes of a small behavioural array, so data can be checked end to end. Reads are flow-through: the output data comes straight from the array at the current beat address, with no output register. The data bus is modelled as separate in and out vectors plus a drive enable. That enable is high only when the device is selected, the last sampled cycle was a read, and output enable is low.

Top module: `bsram_ctl`

## Requirements
- R1: With `strb_proc_n` low, `cs_main_n` low, `cs_lo_n` low and `cs_hi` high, the address is captured at the edge and the burst starts at beat 0. After that edge `rdata_o` shows the word at the captured address, and `drive_o` is high if `oe_n` is low.
- R2: A processor strobe sampled while `cs_main_n` is high is ignored. A running burst continues or suspends according to `adv_n`, as if no strobe were present.
- R3: When the processor strobe is not taken, a low `strb_ctrl_n` starts a cycle if all three chip enables are active and deselects the device otherwise. When both strobes are low with `cs_main_n` low, the processor strobe wins and the cycle is a read.
- R4: On an edge that accepts the processor strobe, `adv_n` and all write inputs are ignored. The burst starts at beat 0 as a read.
- R5: On an edge that accepts the controller strobe, the write inputs are sampled, and a write stores `wdata_i` at the newly presented address.
- R6: With both strobes high and the device selected, `adv_n` low moves to the next beat after the access. `adv_n` high holds the current beat address. This applies to reads and to writes.
- R7: With `order_xor` high at the loading edge, beat n (n = 0..3) uses the two low address bits XOR n.
- R8: With `order_xor` low at the loading edge, beat n uses (low bits + n) mod 4. In both orders the upper address bits never change during a burst, and the fifth beat returns to the first address.
- R9: `wr_all_n` low writes all byte lanes, whatever `wr_byte_en_n` and `lane_wr_n` are.
- R10: With `wr_all_n` high and `wr_byte_en_n` low, only the lanes whose `lane_wr_n` bit is low are written (bit i is byte lane i, bits 8i+7..8i). With no lane selected, or with both `wr_all_n` and `wr_byte_en_n` high, the cycle is a read.
- R11: After an edge at which any lane was written, `drive_o` is low even with `oe_n` low.
- R12: A processor strobe with `cs_main_n` low but `cs_lo_n` high or `cs_hi` low deselects the device. While deselected, `drive_o` is low and advancing has no effect.
- R13: `drive_o` is high only when the device is selected, the last edge wrote nothing, and `oe_n` is low. `rdata_o` is the array word at the current beat address in the same cycle.
- R14: After synchronous reset the device is deselected and `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Word address presented with a strobe |
| cs_main_n | input | 1 | Master chip enable, active low, gates the processor strobe |
| cs_lo_n | input | 1 | Second chip enable, active low |
| cs_hi | input | 1 | Third chip enable, active high |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Burst order at load: 1 XOR, 0 linear add |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_en_n | input | 1 | Enables the per-lane byte writes, active low |
| lane_wr_n | input | NB | Per-lane byte write, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata_i | input | NB*LW | Write data |
| rdata_o | output | NB*LW | Flow-through read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
The bench writes every word, reads every word back, and runs bursts from all four start offsets in both orders at two upper-address values. A burst whose upper bits moved, or whose order was wrong, would return another word's pattern. All sixteen lane masks are swept on one word against a shadow copy, so a wrongly decoded lane would corrupt or keep the wrong byte. A drive enable that ignored a sampled write would be caught the cycle after the write. The strobe corner cases are driven directly and observed on `drive_o` and `rdata_o`. These are a blocked processor strobe, both strobes low together, and each inactive chip enable. An arbiter with the wrong priority would show up as a spurious write, a lost burst or a bus driven while deselected.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
// bsram_pkg: shared types and the beat address function of the burst SRAM
// controller. Assumes a 4-beat burst, so the beat count is 2 bits wide.
package bsram_pkg;

    // Kind of cycle decided at one clock edge by the strobe arbiter.
    typedef enum logic [2:0] {
        ACT_IDLE      = 3'd0,  // not selected, no strobe: nothing happens
        ACT_DESEL     = 3'd1,  // strobe with a chip enable inactive
        ACT_LOAD_PROC = 3'd2,  // processor strobe accepted, read start
        ACT_LOAD_CTRL = 3'd3,  // controller strobe accepted, may write
        ACT_CONT      = 3'd4   // selected, no strobe: continue or suspend
    } cyc_act_e;

    // Low two address bits of the current beat, in XOR or linear order.
    function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       xor_mode);
        return xor_mode ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/bsram_strobe_arb.sv
`timescale 1ns/1ps
// bsram_strobe_arb: decides per clock edge which cycle kind applies.
// The processor strobe counts only with the master enable active and then
// has priority; otherwise the controller strobe is considered. With no
// strobe, a selected device continues its burst. Purely combinational.
module bsram_strobe_arb
    import bsram_pkg::*;
(
    input  logic     strb_proc_n,
    input  logic     strb_ctrl_n,
    input  logic     cs_main_n,
    input  logic     cs_lo_n,
    input  logic     cs_hi,
    input  logic     sel_q,
    output cyc_act_e act
);

    logic en_all;
    logic proc_seen;

    // All three chip enables active, and processor strobe not blocked.
    always_comb begin
        en_all    = !cs_main_n && !cs_lo_n && cs_hi;
        proc_seen = !strb_proc_n && !cs_main_n;
    end

    // Priority decode of the cycle kind.
    always_comb begin
        if (proc_seen) begin
            act = en_all ? ACT_LOAD_PROC : ACT_DESEL;
        end else if (!strb_ctrl_n) begin
            act = en_all ? ACT_LOAD_CTRL : ACT_DESEL;
        end else if (sel_q) begin
            act = ACT_CONT;
        end else begin
            act = ACT_IDLE;
        end
    end

endmodule

// File: rtl/bsram_burst_addr.sv
`timescale 1ns/1ps
// bsram_burst_addr: holds the loaded address, the beat count, the order
// and the selected flag. Only the two low bits follow the beat count; the
// upper bits stay as loaded. The order input is captured at the load edge.
// Assumes AW >= 3.
module bsram_burst_addr
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_act_e      act,
    input  logic [AW-1:0] addr_i,
    input  logic          adv_n,
    input  logic          order_xor,
    output logic          sel_q,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          xor_q;

    // Load, advance, suspend or deselect at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            xor_q  <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD_PROC, ACT_LOAD_CTRL: begin
                    base_q <= addr_i;
                    cnt_q  <= 2'd0;
                    xor_q  <= order_xor;
                    sel_q  <= 1'b1;
                end
                ACT_DESEL: begin
                    sel_q <= 1'b0;
                end
                ACT_CONT: begin
                    if (!adv_n) begin
                        cnt_q <= cnt_q + 2'd1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Current beat address from the loaded base and the beat count.
    always_comb begin
        cur_addr = {base_q[AW-1:2], beat_lsb(base_q[1:0], cnt_q, xor_q)};
    end

endmodule

// File: rtl/bsram_wr_dec.sv
`timescale 1ns/1ps
// bsram_wr_dec: turns the global write, byte-write enable and per-lane
// byte writes into one write request per byte lane. Combinational; the
// caller decides on which edges the requests count.
module bsram_wr_dec #(
    parameter int NB = 4
) (
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] lane_wr_n,
    output logic [NB-1:0] lane_req
);

    // One request per lane: global write, or enabled byte write of that lane.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_req[i] = !wr_all_n || (!wr_byte_en_n && !lane_wr_n[i]);
    end

endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
// bsram_array: behavioural storage of 2**AW words with NB lanes of LW bits.
// Each lane has its own write strobe; the read port is asynchronous so the
// controller stays flow-through. The contents are not reset.
module bsram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    we,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Store this lane's byte when its strobe is set.
        always_ff @(posedge clk) begin
            if (we[i]) begin
                mem[waddr] <= wdata[i*LW +: LW];
            end
        end

        // Flow-through read of this lane.
        assign rdata[i*LW +: LW] = mem[raddr];
    end

endmodule

// File: rtl/bsram_ctl.sv
`timescale 1ns/1ps
// bsram_ctl: top of the burst SRAM cycle controller. Combines the strobe
// arbiter, the burst address register, the write decoder and the array.
// Writes happen on controller-strobe edges (at the presented address) and
// on continue edges (at the current beat). The drive enable is low for the
// cycle after any write. Assumes AW >= 3.
module bsram_ctl
    import bsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 8,
    localparam int DW = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          cs_main_n,
    input  logic          cs_lo_n,
    input  logic          cs_hi,
    input  logic          strb_proc_n,
    input  logic          strb_ctrl_n,
    input  logic          adv_n,
    input  logic          order_xor,
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] lane_wr_n,
    input  logic          oe_n,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          drive_o
);

    cyc_act_e      act;
    logic          sel_q;
    logic [AW-1:0] cur_addr;
    logic [NB-1:0] lane_req;
    logic [NB-1:0] mem_we;
    logic [AW-1:0] wr_addr;
    logic          wr_q;

    bsram_strobe_arb arb_i (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .cs_main_n   (cs_main_n),
        .cs_lo_n     (cs_lo_n),
        .cs_hi       (cs_hi),
        .sel_q       (sel_q),
        .act         (act)
    );

    bsram_burst_addr #(.AW(AW)) burst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .addr_i    (addr_i),
        .adv_n     (adv_n),
        .order_xor (order_xor),
        .sel_q     (sel_q),
        .cur_addr  (cur_addr)
    );

    bsram_wr_dec #(.NB(NB)) wdec_i (
        .wr_all_n     (wr_all_n),
        .wr_byte_en_n (wr_byte_en_n),
        .lane_wr_n    (lane_wr_n),
        .lane_req     (lane_req)
    );

    // Lane strobes count only on controller loads and continue edges.
    always_comb begin
        if (act == ACT_LOAD_CTRL || act == ACT_CONT) begin
            mem_we = lane_req;
        end else begin
            mem_we = '0;
        end
        wr_addr = (act == ACT_LOAD_CTRL) ? addr_i : cur_addr;
    end

    // Remember whether the last edge wrote, to keep the bus undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else begin
            wr_q <= |mem_we;
        end
    end

    bsram_array #(.AW(AW), .NB(NB), .LW(LW)) array_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wdata_i),
        .raddr (cur_addr),
        .rdata (rdata_o)
    );

    // Bus drive: selected read cycle with output enable active.
    always_comb begin
        drive_o = sel_q && !wr_q && !oe_n;
    end

endmodule

// File: rtl/bsram_ctl_chk.sv
`timescale 1ns/1ps
// bsram_ctl_chk: temporal checks on the controller, bound to bsram_ctl.
// Assumes the order input is only sampled at load edges, as the design does.
module bsram_ctl_chk #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_proc_n,
    input logic          strb_ctrl_n,
    input logic          cs_main_n,
    input logic          cs_lo_n,
    input logic          cs_hi,
    input logic          adv_n,
    input logic [AW-1:0] addr_i,
    input logic [AW-1:0] cur_addr,
    input logic [NB-1:0] mem_we,
    input logic          drive_o
);

    AST_PROC_LOADS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !cs_main_n && !cs_lo_n && cs_hi) |=> (cur_addr == $past(addr_i))); // R1

    AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && cs_main_n && strb_ctrl_n && adv_n) |=> $stable(cur_addr)); // R2

    AST_CTRL_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctrl_n && cs_main_n) |=> !drive_o); // R3

    AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !cs_main_n) |-> (mem_we == '0)); // R4

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_proc_n && strb_ctrl_n && adv_n) |=> $stable(cur_addr)); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_proc_n && strb_ctrl_n) |=> $stable(cur_addr[AW-1:2])); // R8

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |=> !drive_o); // R11

    AST_PROC_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !cs_main_n && (cs_lo_n || !cs_hi)) |=> !drive_o); // R12

endmodule

bind bsram_ctl bsram_ctl_chk #(.AW(AW), .NB(NB)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .cs_main_n   (cs_main_n),
    .cs_lo_n     (cs_lo_n),
    .cs_hi       (cs_hi),
    .adv_n       (adv_n),
    .addr_i      (addr_i),
    .cur_addr    (cur_addr),
    .mem_we      (mem_we),
    .drive_o     (drive_o)
);

// File: tb/bsram_ctl_tb.sv
`timescale 1ns/1ps
module bsram_ctl_tb_top;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int LW = 8;
    localparam int DW = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i;
    logic          cs_main_n, cs_lo_n, cs_hi;
    logic          strb_proc_n, strb_ctrl_n, adv_n, order_xor;
    logic          wr_all_n, wr_byte_en_n, oe_n;
    logic [NB-1:0] lane_wr_n;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          drive_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] sh [DEPTH];

    bsram_ctl #(.AW(AW), .NB(NB), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .cs_main_n(cs_main_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .adv_n(adv_n), .order_xor(order_xor),
        .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n),
        .lane_wr_n(lane_wr_n), .oe_n(oe_n),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a);
        return {8'(a + 16), 8'(~a), 8'(a * 3), 8'(a ^ 8'h5A)};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        addr_i = '0; cs_main_n = 1'b0; cs_lo_n = 1'b0; cs_hi = 1'b1;
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_en_n = 1'b1; lane_wr_n = '1;
        oe_n = 1'b0; wdata_i = '0;
    endtask

    // One rising edge; outputs are then sampled 2 ns later.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic load_proc(input int a, input logic mode);
        idle(); strb_proc_n = 1'b0; addr_i = AW'(a); order_xor = mode;
        step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(); order_xor = 1'b0;
        repeat (3) step();
        check("R14 reset drive", 32'(drive_o), 32'd0);
        rst_n = 1'b1;

        // R5: fill every word through controller-strobe writes.
        for (int a = 0; a < DEPTH; a++) begin
            idle(); strb_ctrl_n = 1'b0; addr_i = AW'(a);
            wr_all_n = 1'b0; wdata_i = pat(a);
            step();
            sh[a] = pat(a);
            if (a == 5) check("R11 drive after ctrl write", 32'(drive_o), 32'd0);
        end
        idle(); step();
        check("R13 flow-through after write", rdata_o, sh[DEPTH-1]);
        check("R13 drive on read", 32'(drive_o), 32'd1);
        oe_n = 1'b1; #1;
        check("R13 oe high blocks drive", 32'(drive_o), 32'd0);

        // R1 R5: read back every word.
        for (int a = 0; a < DEPTH; a++) begin
            load_proc(a, 1'b0);
            check("R1 R5 read data", rdata_o, sh[a]);
            check("R1 drive", 32'(drive_o), 32'd1);
        end

        // R6 R7 R8: bursts from every start offset in both orders.
        for (int mode = 0; mode < 2; mode++) begin
            for (int up = 1; up < 16; up += 14) begin
                for (int lo = 0; lo < 4; lo++) begin
                    load_proc(up * 4 + lo, mode[0]);
                    check("R7 R8 beat 0", rdata_o, sh[up * 4 + lo]);
                    for (int n = 1; n <= 4; n++) begin
                        int e;
                        idle(); adv_n = 1'b0; step();
                        e = up * 4 + (mode == 1 ? (lo ^ (n & 3)) : ((lo + n) & 3));
                        check(mode == 1 ? "R7 xor beat" : "R8 linear beat", rdata_o, sh[e]);
                        if (n == 2) begin
                            idle(); step();
                            check("R6 suspend holds", rdata_o, sh[e]);
                        end
                    end
                end
            end
        end

        // R4: processor edge ignores advance and writes.
        idle(); strb_proc_n = 1'b0; addr_i = 6'd9; adv_n = 1'b0;
        wr_all_n = 1'b0; wr_byte_en_n = 1'b0; lane_wr_n = '0; order_xor = 1'b0;
        step();
        check("R4 starts at beat 0 unwritten", rdata_o, sh[9]);
        check("R4 starts as read", 32'(drive_o), 32'd1);

        // R10 R11: all sixteen lane masks on word 33.
        for (int m = 0; m < 16; m++) begin
            logic [DW-1:0] wd;
            wd = {4{8'(m * 17 + 1)}};
            load_proc(33, 1'b0);
            idle(); wr_byte_en_n = 1'b0; lane_wr_n = 4'(m); wdata_i = wd;
            step();
            for (int i = 0; i < NB; i++)
                if (!m[i]) sh[33][i*LW +: LW] = wd[i*LW +: LW];
            check("R11 drive after lane write", 32'(drive_o), (m == 15) ? 32'd1 : 32'd0);
            idle(); step();
            check("R10 lane merge", rdata_o, sh[33]);
            check("R10 drive back", 32'(drive_o), 32'd1);
        end
        // R10: byte writes without byte-write enable are a read.
        load_proc(33, 1'b0);
        idle(); lane_wr_n = '0; wdata_i = '0; step();
        check("R10 no enable is read", 32'(drive_o), 32'd1);
        check("R10 no enable keeps data", rdata_o, sh[33]);
        // R9: global write overrides lanes.
        idle(); wr_all_n = 1'b0; lane_wr_n = '1; wdata_i = 32'hDEADBEEF; step();
        sh[33] = 32'hDEADBEEF;
        idle(); step();
        check("R9 global write", rdata_o, sh[33]);

        // R12 R3: deselect variants.
        load_proc(2, 1'b0);
        idle(); strb_proc_n = 1'b0; cs_lo_n = 1'b1; step();
        check("R12 cs_lo_n deselect", 32'(drive_o), 32'd0);
        idle(); adv_n = 1'b0; step();
        check("R12 stays deselected", 32'(drive_o), 32'd0);
        load_proc(2, 1'b0);
        idle(); strb_proc_n = 1'b0; cs_hi = 1'b0; step();
        check("R12 cs_hi deselect", 32'(drive_o), 32'd0);
        load_proc(2, 1'b0);
        idle(); strb_ctrl_n = 1'b0; cs_main_n = 1'b1; step();
        check("R3 ctrl with cs_main_n high deselects", 32'(drive_o), 32'd0);

        // R2: blocked processor strobe lets the burst advance.
        load_proc(44, 1'b0);
        idle(); strb_proc_n = 1'b0; cs_main_n = 1'b1; addr_i = 6'd7; adv_n = 1'b0;
        step();
        check("R2 blocked strobe continues burst", rdata_o, sh[45]);
        check("R2 still driving", 32'(drive_o), 32'd1);

        // R3: both strobes low, processor wins, no write.
        idle(); strb_proc_n = 1'b0; strb_ctrl_n = 1'b0; addr_i = 6'd50;
        wr_all_n = 1'b0; wdata_i = '0; step();
        check("R3 processor priority read", rdata_o, sh[50]);
        check("R3 priority drive", 32'(drive_o), 32'd1);

        // R6: continue writes with advance fill a linear burst.
        load_proc(40, 1'b0);
        for (int n = 0; n < 4; n++) begin
            idle(); wr_all_n = 1'b0; adv_n = 1'b0; wdata_i = 32'hA0000000 + 32'(n);
            step();
            sh[40 + n] = 32'hA0000000 + 32'(n);
        end
        load_proc(40, 1'b0);
        check("R6 write burst beat 0", rdata_o, sh[40]);
        for (int n = 1; n < 4; n++) begin
            idle(); adv_n = 1'b0; step();
            check("R6 write burst beat", rdata_o, sh[40 + n]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule